// File: doc/BRIEF.md
# SPI Flash Status-Register Emulator

This block sits on the target side of a single-lane SPI bus and behaves, for the status and addressing commands only, like a serial NOR flash. It keeps a 24-bit status word, a write-enable latch held in bit 1 of that word, and a flag that selects 3-byte or 4-byte addressing. A host reads the status word one byte at a time through three separate read opcodes. It changes the latch and the address mode with single-byte opcodes.

The SPI pins are oversampled in the system clock domain through two-flop synchronisers. Local logic can stage a new status value through a register-side write port. The staged value reaches the SPI-visible register only when chip select next rises. A read port shows the live status word and the address-mode flag at all times.

Top module: `spi_stat_emu`

## Requirements
- R1: SPI mode 0 is used. MOSI is taken on rising SCK, MSB first. An opcode counts only when all 8 of its bits arrived before CSn rose. A transaction with fewer bits changes neither the write-enable latch nor the address mode.
- R2: A complete opcode 0x06 sets status bit 1, and a complete opcode 0x04 clears it. The change is applied on the CSn low-to-high transition that ends the transaction.
- R3: Opcode 0x05 returns status bits 7:0, opcode 0x35 returns bits 15:8 and opcode 0x15 returns bits 23:16. The byte goes out MSB first on MISO and changes after each falling SCK edge, starting with the falling edge that follows the 8th opcode bit. MISO is 0 for any bit after the returned byte.
- R4: A complete opcode 0xB7 sets `addr4_mode`, and a complete opcode 0xE9 clears it. Both take effect on the CSn rise that ends the transaction.
- R5: A `reg_wr_en` pulse stores `reg_wr_data` in a staging register. The staged value is copied into the status word on the next CSn rise, whatever the opcode, even for a partial byte. Until then, SPI reads and `stat_rd` show the previous value. If that transaction also carries 0x06 or 0x04, the opcode's change to bit 1 is applied on top of the copied value.
- R6: `stat_rd` always shows the live status word, including bit 1 changes made by SPI opcodes.
- R7: An opcode other than 0x06, 0x04, 0x05, 0x35, 0x15, 0xB7 and 0xE9 leaves the status word and the address mode unchanged, and MISO stays 0 during its read phase.
- R8: Reset clears the status word, the staging register and `addr4_mode`. MISO is 0 whenever CSn is high.
- R9: Status bit 0 is the busy flag. It is set only by a register-side write, and opcode 0x05 returns it in the least significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which also oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock from the host, idle low |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| reg_wr_en | input | 1 | One-cycle strobe that stages `reg_wr_data` |
| reg_wr_data | input | 24 | Status value to stage |
| stat_rd | output | 24 | Live status word |
| addr4_mode | output | 1 | 1 when 4-byte addressing is active |

## Verification
Single-byte state opcodes are sent both complete and cut short after 5 or 7 bits. This separates commit-on-CSn-rise from commit-on-bit-count. Each of the three read opcodes is issued against the asymmetric pattern 0x5A55AA, so any swap of bytes or bit order shows up. A value staged before a transaction is read inside that same transaction and then again afterwards, which tells the latch-at-CSn-rise behaviour apart from an immediate update. Staging a value and sending 0x06 in one transaction shows that the opcode is applied on top of the copied value. An unknown opcode with a read phase confirms that MISO stays quiet and that no state changes.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

    localparam int STAT_W  = 24;
    localparam int BYTE_W  = 8;
    localparam int WEL_BIT = 1;

    typedef enum logic [7:0] {
        OP_WEL_SET  = 8'h06,
        OP_WEL_CLR  = 8'h04,
        OP_RD_LOW   = 8'h05,
        OP_RD_MID   = 8'h35,
        OP_RD_HIGH  = 8'h15,
        OP_WIDE_ON  = 8'hB7,
        OP_WIDE_OFF = 8'hE9
    } op_e;

    typedef struct packed {
        logic sck;
        logic csn;
        logic mosi;
    } pins_t;

    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic cs_rise;
        logic cs_act;
        logic mosi;
    } pin_evt_t;

    localparam pins_t PINS_IDLE = '{sck: 1'b0, csn: 1'b1, mosi: 1'b0};

    function automatic logic [BYTE_W-1:0] resp_byte(logic [BYTE_W-1:0] op,
                                                    logic [STAT_W-1:0] st);
        case (op)
            OP_RD_LOW:  return st[7:0];
            OP_RD_MID:  return st[15:8];
            OP_RD_HIGH: return st[23:16];
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
    import spi_stat_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  pins_t    raw,
    output pin_evt_t evt
);
    localparam int NPIN = $bits(pins_t);
    localparam logic [NPIN-1:0] IDLE_V = PINS_IDLE;

    logic [NPIN-1:0] raw_v;
    logic [NPIN-1:0] synced;
    pins_t           cur;
    pins_t           prev;

    assign raw_v = raw;

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{IDLE_V[p]}};
            else     chain <= {chain[STAGES-2:0], raw_v[p]};
        end
        assign synced[p] = chain[STAGES-1];
    end

    assign cur = pins_t'(synced);

    always_ff @(posedge clk) begin
        if (rst) prev <= PINS_IDLE;
        else     prev <= cur;
    end

    assign evt.sck_rise = cur.sck & ~prev.sck;
    assign evt.sck_fall = ~cur.sck & prev.sck;
    assign evt.cs_rise  = cur.csn & ~prev.csn;
    assign evt.cs_act   = ~cur.csn;
    assign evt.mosi     = cur.mosi;
endmodule

// File: rtl/spi_op_shift.sv
module spi_op_shift
    import spi_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pin_evt_t          evt,
    input  logic [STAT_W-1:0] status,
    output logic [BYTE_W-1:0] op,
    output logic              op_done,
    output logic              miso
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] tx;
    logic              loaded;

    always_ff @(posedge clk) begin
        if (rst || !evt.cs_act) begin
            cnt    <= '0;
            op     <= '0;
            tx     <= '0;
            loaded <= 1'b0;
        end else begin
            if (evt.sck_rise && cnt != FULL) begin
                op  <= {op[BYTE_W-2:0], evt.mosi};
                cnt <= cnt + 1'b1;
            end
            if (evt.sck_fall) begin
                if (cnt == FULL && !loaded) begin
                    tx     <= resp_byte(op, status);
                    loaded <= 1'b1;
                end else begin
                    tx <= {tx[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign op_done = (cnt == FULL);
    assign miso    = tx[BYTE_W-1];
endmodule

// File: rtl/spi_stat_regs.sv
module spi_stat_regs
    import spi_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_rise,
    input  logic [BYTE_W-1:0] op,
    input  logic              op_done,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] status,
    output logic              mode4,
    output logic              pend
);
    logic [STAT_W-1:0] stage;
    logic [STAT_W-1:0] status_n;
    logic              mode_n;

    always_comb begin
        status_n = pend ? stage : status;
        mode_n   = mode4;
        if (op_done) begin
            case (op)
                OP_WEL_SET:  status_n[WEL_BIT] = 1'b1;
                OP_WEL_CLR:  status_n[WEL_BIT] = 1'b0;
                OP_WIDE_ON:  mode_n = 1'b1;
                OP_WIDE_OFF: mode_n = 1'b0;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage  <= '0;
            pend   <= 1'b0;
            status <= '0;
            mode4  <= 1'b0;
        end else begin
            if (wr_en) stage <= wr_data;
            pend <= wr_en | (pend & ~cs_rise);
            if (cs_rise) begin
                status <= status_n;
                mode4  <= mode_n;
            end
        end
    end
endmodule

// File: rtl/spi_stat_emu.sv
module spi_stat_emu
    import spi_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              reg_wr_en,
    input  logic [STAT_W-1:0] reg_wr_data,
    output logic [STAT_W-1:0] stat_rd,
    output logic              addr4_mode
);
    pins_t             raw;
    pin_evt_t          evt;
    logic [BYTE_W-1:0] op_byte;
    logic              op_done;
    logic              stage_pend;
    logic              cs_rise;
    logic              cs_act;

    assign raw     = '{sck: spi_sck, csn: spi_csn, mosi: spi_mosi};
    assign cs_rise = evt.cs_rise;
    assign cs_act  = evt.cs_act;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .raw (raw),
        .evt (evt)
    );

    spi_op_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .status  (stat_rd),
        .op      (op_byte),
        .op_done (op_done),
        .miso    (spi_miso)
    );

    spi_stat_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .cs_rise (cs_rise),
        .op      (op_byte),
        .op_done (op_done),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .status  (stat_rd),
        .mode4   (addr4_mode),
        .pend    (stage_pend)
    );
endmodule

// File: rtl/spi_stat_emu_chk.sv
module spi_stat_emu_chk (
    input logic        clk,
    input logic        rst,
    input logic        cs_act,
    input logic        cs_rise,
    input logic [7:0]  op_byte,
    input logic        op_done,
    input logic        stage_pend,
    input logic        spi_miso,
    input logic [23:0] stat_rd,
    input logic        addr4_mode
);
    logic state_op;
    assign state_op = op_done && (op_byte == 8'h06 || op_byte == 8'h04 ||
                                  op_byte == 8'hB7 || op_byte == 8'hE9);

    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> !spi_miso);                                            // R8
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cs_rise |=> $stable(stat_rd));                                    // R5
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cs_rise |=> $stable(addr4_mode));                                 // R4
    AST_WEL_SET: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && op_done && op_byte == 8'h06) |=> stat_rd[1]);          // R2
    AST_WEL_CLR: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && op_done && op_byte == 8'h04) |=> !stat_rd[1]);         // R2
    AST_WIDE_ON: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && op_done && op_byte == 8'hB7) |=> addr4_mode);          // R4
    AST_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && !stage_pend && !state_op)
            |=> ($stable(stat_rd) && $stable(addr4_mode)));                // R7
endmodule

bind spi_stat_emu spi_stat_emu_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_act     (cs_act),
    .cs_rise    (cs_rise),
    .op_byte    (op_byte),
    .op_done    (op_done),
    .stage_pend (stage_pend),
    .spi_miso   (spi_miso),
    .stat_rd    (stat_rd),
    .addr4_mode (addr4_mode)
);

// File: tb/tb_spi_stat_emu.sv
`timescale 1ns/1ps
module tb_spi_stat_emu;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sck = 1'b0;
    logic        spi_csn = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        reg_wr_en = 1'b0;
    logic [23:0] reg_wr_data = '0;
    logic [23:0] stat_rd;
    logic        addr4_mode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit cmp_en = 1'b0;

    logic [23:0] m_status = '0;
    logic [23:0] m_stage = '0;
    bit          m_pend = 1'b0;
    bit          m_mode = 1'b0;
    logic        extra_bit;

    always #2 clk = ~clk;

    spi_stat_emu dut (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_csn(spi_csn),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .stat_rd(stat_rd), .addr4_mode(addr4_mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the behavioural model (R6, R4)
    always @(negedge clk) begin
        if (!rst && cmp_en) begin
            chk("R6 live status", {8'h0, stat_rd}, {8'h0, m_status});
            chk("R4 mode flag", {31'h0, addr4_mode}, {31'h0, m_mode});
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] op);
        case (op)
            8'h05:   return m_status[7:0];
            8'h35:   return m_status[15:8];
            8'h15:   return m_status[23:16];
            default: return 8'h00;
        endcase
    endfunction

    task automatic reg_write(input logic [23:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wr_data = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
        m_stage = v;
        m_pend = 1'b1;
    endtask

    task automatic spi_txn(input logic [7:0] op, input int nbits, input bit rd,
                           output logic [7:0] rb);
        rb = '0;
        extra_bit = 1'b0;
        @(negedge clk);
        spi_csn = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = op[7-i];
            wait_clk(HALF);
            spi_sck = 1'b1;
            wait_clk(HALF);
            spi_sck = 1'b0;
        end
        if (rd) begin
            for (int i = 0; i < 9; i++) begin
                spi_mosi = 1'b0;
                wait_clk(HALF);
                if (i < 8) rb = {rb[6:0], spi_miso};
                else       extra_bit = spi_miso;
                spi_sck = 1'b1;
                wait_clk(HALF);
                spi_sck = 1'b0;
            end
        end
        wait_clk(HALF);
        cmp_en = 1'b0;
        wait_clk(1);
        spi_csn = 1'b1;
        wait_clk(8);
        if (m_pend) begin
            m_status = m_stage;
            m_pend = 1'b0;
        end
        if (nbits >= 8) begin
            case (op)
                8'h06: m_status[1] = 1'b1;
                8'h04: m_status[1] = 1'b0;
                8'hB7: m_mode = 1'b1;
                8'hE9: m_mode = 1'b0;
                default: ;
            endcase
        end
        cmp_en = 1'b1;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] op);
        logic [7:0] e;
        logic [7:0] rb;
        e = exp_rd(op);
        spi_txn(op, 8, 1'b1, rb);
        chk(req, {24'h0, rb}, {24'h0, e});
    endtask

    task automatic do_reset();
        cmp_en = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        wait_clk(4);
        rst = 1'b0;
        m_status = '0; m_stage = '0; m_pend = 1'b0; m_mode = 1'b0;
        wait_clk(2);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rb;
        logic [23:0] acc;
        do_reset();
        // R8 reset state
        chk("R8 reset status", {8'h0, stat_rd}, 32'h0);
        chk("R8 reset mode", {31'h0, addr4_mode}, 32'h0);
        chk("R8 idle miso", {31'h0, spi_miso}, 32'h0);
        cmp_en = 1'b1;

        rd_chk("R3 read low after reset", 8'h05);

        // R2 write-enable set and clear
        spi_txn(8'h06, 8, 1'b0, rb);
        chk("R2 set bit1", {31'h0, stat_rd[1]}, 32'h1);
        rd_chk("R6 read low shows WEL", 8'h05);
        spi_txn(8'h04, 8, 1'b0, rb);
        chk("R2 clear bit1", {31'h0, stat_rd[1]}, 32'h0);

        // R4 address mode
        spi_txn(8'hB7, 8, 1'b0, rb);
        chk("R4 enter wide", {31'h0, addr4_mode}, 32'h1);
        spi_txn(8'hE9, 8, 1'b0, rb);
        chk("R4 exit wide", {31'h0, addr4_mode}, 32'h0);

        // R1 partial opcodes ignored
        spi_txn(8'h06, 5, 1'b0, rb);
        chk("R1 partial set ignored", {8'h0, stat_rd}, 32'h0);
        spi_txn(8'hB7, 7, 1'b0, rb);
        chk("R1 partial wide ignored", {31'h0, addr4_mode}, 32'h0);

        // R7 unknown opcode
        spi_txn(8'h06, 8, 1'b0, rb);
        spi_txn(8'h9F, 8, 1'b1, rb);
        chk("R7 unknown miso", {24'h0, rb}, 32'h0);
        chk("R7 unknown keeps state", {8'h0, stat_rd}, 32'h2);
        spi_txn(8'h04, 8, 1'b0, rb);

        // R5 staging until CSn rise
        reg_write(24'h5A55AA);
        wait_clk(4);
        chk("R5 staged not live", {8'h0, stat_rd}, 32'h0);
        spi_txn(8'h05, 8, 1'b1, rb);
        chk("R5 read before latch", {24'h0, rb}, 32'h0);
        chk("R5 latched after rise", {8'h0, stat_rd}, 32'h5A55AA);

        // R3 three-byte assembly
        acc = '0;
        spi_txn(8'h05, 8, 1'b1, rb); acc[7:0] = rb;
        chk("R3 trailing miso zero", {31'h0, extra_bit}, 32'h0);
        spi_txn(8'h35, 8, 1'b1, rb); acc[15:8] = rb;
        spi_txn(8'h15, 8, 1'b1, rb); acc[23:16] = rb;
        chk("R3 assembled status", {8'h0, acc}, 32'h5A55AA);

        // R2 clear on a latched value
        spi_txn(8'h04, 8, 1'b0, rb);
        chk("R2 clear on pattern", {8'h0, stat_rd}, 32'h5A55A8);

        // R9 busy bit through a no-op latch
        reg_write(24'h000001);
        chk("R5 no change before nop", {8'h0, stat_rd}, 32'h5A55A8);
        spi_txn(8'h00, 8, 1'b0, rb);
        chk("R5 nop latches", {8'h0, stat_rd}, 32'h000001);
        rd_chk("R9 busy via read low", 8'h05);

        // R5 opcode applied on top of staged value in one transaction
        reg_write(24'h123400);
        spi_txn(8'h06, 8, 1'b0, rb);
        chk("R5 stage plus set", {8'h0, stat_rd}, 32'h123402);
        rd_chk("R3 read mid", 8'h35);
        rd_chk("R3 read high", 8'h15);

        // R5 partial byte still latches staged value
        reg_write(24'h00ABCD);
        spi_txn(8'h06, 3, 1'b0, rb);
        chk("R5 partial latches stage", {8'h0, stat_rd}, 32'h00ABCD);

        // R8 reset clears mode and status
        spi_txn(8'hB7, 8, 1'b0, rb);
        do_reset();
        chk("R8 reset clears status", {8'h0, stat_rd}, 32'h0);
        chk("R8 reset clears mode", {31'h0, addr4_mode}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule